// File: doc/BRIEF.md
# Single-Level Two-Source Interrupt Sequencer

This block decides when a small 8-bit controller core must break off its program to service an interrupt. There are two sources: a host-side input-buffer-full request, which is level-sensitive, and a timer/counter overflow event, which is latched. Each source has its own enable flag, switched on and off by strobes that the instruction decoder raises. At an instruction boundary, which the core marks with a fetch strobe, the block picks the highest-priority enabled request. It then issues a one-cycle forced-call request that carries the vector address of the chosen source.

The scheme has one level only. Once a call has been issued, an in-service flag blocks further calls until the second cycle of a return-and-restore instruction re-arms the block. Requests that arrive while the flag is set are kept and not lost. A timer overflow stays pending, and a buffer-full request that is still held is taken again as soon as recognition is re-armed. The buffer-full source has fixed priority over the timer.

Top module: `irq_single_level_ctrl`

## Requirements
- R1: After reset, call_o and vec_o are 0 and both source enables are off, so no call is issued on a fetch even when both sources request.
- R2: A pulse on a source's enable strobe turns that source on, and a pulse on its disable strobe turns it off. If both strobes are high in the same cycle, the source ends up off.
- R3: call_o goes high for exactly one cycle, in the cycle after a cycle with fetch_i high in which recognition was armed and at least one enabled source was requesting. Without fetch_i, no call is issued.
- R4: While call_o is high, vec_o shows 3 for the buffer-full source and 7 for the timer source. While call_o is low, vec_o is 0.
- R5: When both enabled sources request at the same boundary, the buffer-full source is called. The timer event stays pending and is called at a later armed boundary.
- R6: From the edge that issues a call until re-arm, fetch_i produces no call. A timer overflow that arrives during that interval is kept pending.
- R7: Recognition is re-armed in a cycle where retr_i and retr_cyc2_i are both high. A fetch in that same cycle can already issue a call. retr_i with retr_cyc2_i low does not re-arm. A buffer-full request still held at re-arm is taken again.
- R8: The timer pending flag is cleared by the edge that issues the timer call. An overflow pulse in that same cycle leaves the flag set, so a second timer call follows at the next armed boundary.
- R9: The buffer-full request is not latched. If it drops before the boundary, no call is issued for it.
- R10: A timer overflow that occurs while the timer source is disabled stays pending. It is called at a boundary after the source has been enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ibf_req_i | input | 1 | Input-buffer-full request, level |
| tmr_ovf_i | input | 1 | Timer overflow event, one-cycle pulse |
| ibf_en_set_i | input | 1 | Enable strobe for the buffer-full source |
| ibf_en_clr_i | input | 1 | Disable strobe for the buffer-full source |
| tmr_en_set_i | input | 1 | Enable strobe for the timer source |
| tmr_en_clr_i | input | 1 | Disable strobe for the timer source |
| fetch_i | input | 1 | Instruction boundary marker from the core |
| retr_i | input | 1 | Return-and-restore instruction executing |
| retr_cyc2_i | input | 1 | High during that instruction's second cycle |
| call_o | output | 1 | Forced-call request, one cycle |
| vec_o | output | PC_W | Vector address of the forced call |

## Verification
Two events can fall in one cycle and need a defined result. First, the re-arm from the return instruction can coincide with a fetch boundary, and a timer call can be issued in the cycle where a fresh overflow pulse arrives. The bench provokes the first by driving retr_i, retr_cyc2_i and fetch_i together while a request is waiting; it expects a call with the right vector on the following cycle. It provokes the second by pulsing tmr_ovf_i in the very fetch cycle that issues the timer call; it expects one more timer call after the next re-arm, whereas the same sequence without the coinciding pulse yields none.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // source indices; lower index wins arbitration
  localparam int unsigned SRC_IBF = 0;
  localparam int unsigned SRC_TMR = 1;
  localparam int unsigned NSRC    = 2;
  // bit set: source is an event that must be held until called
  localparam logic [NSRC-1:0] LATCH_MASK = 2'b10;
endpackage

// File: rtl/irqc_enable_flag.sv
module irqc_enable_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (set_i) en_d = 1'b1;
    if (clr_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !en_o);
  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> en_o);
endmodule

// File: rtl/irqc_pend_latch.sv
module irqc_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic taken_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  // a new event outranks the clear caused by a call issued in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (taken_i) pend_d = 1'b0;
    if (event_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> pend_o);
  assert_taken_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_i && !event_i) |=> !pend_o);
endmodule

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_single_level_ctrl.sv
module irq_single_level_ctrl #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned IBF_VEC = 3,
  parameter int unsigned TMR_VEC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ibf_req_i,
  input  logic            tmr_ovf_i,
  input  logic            ibf_en_set_i,
  input  logic            ibf_en_clr_i,
  input  logic            tmr_en_set_i,
  input  logic            tmr_en_clr_i,
  input  logic            fetch_i,
  input  logic            retr_i,
  input  logic            retr_cyc2_i,
  output logic            call_o,
  output logic [PC_W-1:0] vec_o
);
  import irqc_pkg::*;

  localparam logic [PC_W-1:0] VEC_TAB [NSRC] = '{PC_W'(IBF_VEC), PC_W'(TMR_VEC)};

  logic [NSRC-1:0] raw, en_set, en_clr, en, req, elig, grant, taken;
  logic            any, rearm, armed, issue;
  logic            in_svc_q, in_svc_d;
  logic            call_q, call_d;
  logic [PC_W-1:0] vec_q, vec_d;

  assign raw    = {tmr_ovf_i, ibf_req_i};
  assign en_set = {tmr_en_set_i, ibf_en_set_i};
  assign en_clr = {tmr_en_clr_i, ibf_en_clr_i};

  // per-source enable flag and request stage
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqc_enable_flag u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (en_set[i]),
      .clr_i (en_clr[i]),
      .en_o  (en[i])
    );
    if (LATCH_MASK[i]) begin : g_latched
      irqc_pend_latch u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (raw[i]),
        .taken_i (taken[i]),
        .pend_o  (req[i])
      );
    end else begin : g_level
      assign req[i] = raw[i];
    end
  end

  assign elig = req & en;

  irqc_prio_arb #(.N(NSRC)) u_arb (
    .req_i   (elig),
    .grant_o (grant),
    .any_o   (any)
  );

  // re-arm takes effect within the second cycle of the return instruction
  assign rearm = retr_i & retr_cyc2_i;
  assign armed = ~in_svc_q | rearm;
  assign issue = fetch_i & armed & any;
  assign taken = issue ? grant : '0;

  always_comb begin
    in_svc_d = in_svc_q;
    if (rearm) in_svc_d = 1'b0;
    if (issue) in_svc_d = 1'b1;
    call_d = issue;
    vec_d  = '0;
    if (issue) begin
      for (int i = 0; i < NSRC; i++) begin
        if (grant[i]) vec_d = vec_d | VEC_TAB[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      call_q   <= 1'b0;
      vec_q    <= '0;
    end else begin
      in_svc_q <= in_svc_d;
      call_q   <= call_d;
      vec_q    <= vec_d;
    end
  end

  assign call_o = call_q;
  assign vec_o  = vec_q;

  assert_call_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(fetch_i));
  assert_call_sets_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> in_svc_q);
  assert_blocked_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_q && !rearm) |=> !call_o);
  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> (vec_o == PC_W'(IBF_VEC) || vec_o == PC_W'(TMR_VEC)));
  assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !call_o |-> (vec_o == '0));
  assert_ibf_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && elig[SRC_IBF]) |=> (vec_o == PC_W'(IBF_VEC)));
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(en != '0));
endmodule

// File: tb/test_irq_single_level_ctrl.sv
module test_irq_single_level_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ibf_req, tmr_ovf, ibf_set, ibf_clr, tmr_set, tmr_clr;
  logic fetch, retr, retr2;
  logic call;
  logic [PC_W-1:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_single_level_ctrl #(.PC_W(PC_W), .IBF_VEC(3), .TMR_VEC(7)) i_irq_single_level_ctrl (
    .clk(clk), .rst_n(rst_n), .ibf_req_i(ibf_req), .tmr_ovf_i(tmr_ovf),
    .ibf_en_set_i(ibf_set), .ibf_en_clr_i(ibf_clr),
    .tmr_en_set_i(tmr_set), .tmr_en_clr_i(tmr_clr),
    .fetch_i(fetch), .retr_i(retr), .retr_cyc2_i(retr2),
    .call_o(call), .vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // check both outputs at once
  task automatic chk_out(input string tag, input int ec, input int ev);
    chk({tag, " call"}, int'(call), ec);
    chk({tag, " vec"}, int'(vec), ev);
  endtask

  // one cycle: inputs driven at this negedge, edge passes, back at next negedge;
  // pulse inputs drop afterwards
  task automatic tick();
    @(negedge clk);
    tmr_ovf = 0; ibf_set = 0; ibf_clr = 0; tmr_set = 0; tmr_clr = 0;
    fetch = 0; retr = 0; retr2 = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    ibf_req = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tmr_ovf = 0; ibf_set = 0; ibf_clr = 0; tmr_set = 0; tmr_clr = 0;
    fetch = 0; retr = 0; retr2 = 0; ibf_req = 0;
    @(negedge clk);
    do_reset();

    // R1: reset state, then requests with no enables
    chk_out("R1 reset", 0, 0);
    ibf_req = 1; tmr_ovf = 1; tick();
    fetch = 1; tick();
    chk_out("R1 no enable", 0, 0);

    // R2: set and clear together leave the source off
    do_reset();
    ibf_req = 1; ibf_set = 1; ibf_clr = 1; tick();
    fetch = 1; tick();
    chk_out("R2 clr wins", 0, 0);
    ibf_set = 1; tick();
    ibf_clr = 1; tick();
    fetch = 1; tick();
    chk_out("R2 disabled", 0, 0);

    // R3: no call without fetch, single-cycle pulse
    ibf_set = 1; tick();
    tick();
    chk_out("R3 no fetch", 0, 0);
    fetch = 1; tick();
    chk_out("R3 call", 1, 3);
    tick();
    chk_out("R3 one cycle", 0, 0);

    // R6: in service, held request and fetch give nothing; overflow kept
    tmr_set = 1; fetch = 1; tmr_ovf = 1; tick();
    chk_out("R6 blocked", 0, 0);
    // R7: return without cycle-2 does not re-arm
    retr = 1; fetch = 1; tick();
    chk_out("R7 cyc1 no rearm", 0, 0);
    // R7: re-arm then separate fetch retakes held IBF first (R5)
    retr = 1; retr2 = 1; tick();
    chk_out("R7 rearm alone", 0, 0);
    fetch = 1; tick();
    chk_out("R7 ibf retaken", 1, 3);
    // R5/R6: drop IBF, re-arm with fetch in same cycle -> pending timer
    ibf_req = 0; retr = 1; retr2 = 1; fetch = 1; tick();
    chk_out("R6 timer kept", 1, 7);

    // R9: IBF dropped before boundary is forgotten
    do_reset();
    ibf_set = 1; ibf_req = 1; tick();
    ibf_req = 0; tick();
    fetch = 1; tick();
    chk_out("R9 level", 0, 0);

    // R10: overflow while timer disabled stays pending
    do_reset();
    tmr_ovf = 1; tick();
    fetch = 1; tick();
    chk_out("R10 disabled", 0, 0);
    tmr_set = 1; tick();
    fetch = 1; tick();
    chk_out("R10 after enable", 1, 7);

    // R8: overflow in the very cycle its call is issued stays pending
    do_reset();
    tmr_set = 1; tmr_ovf = 1; tick();
    fetch = 1; tmr_ovf = 1; tick();
    chk_out("R8 first call", 1, 7);
    retr = 1; retr2 = 1; fetch = 1; tick();
    chk_out("R8 second call", 1, 7);
    retr = 1; retr2 = 1; fetch = 1; tick();
    chk_out("R8 drained", 0, 0);

    // sweep: enables x IBF level x timer pending (R4, R5, R7, R8)
    for (int c = 0; c < 16; c++) begin
      int ie, te, ir, tp, ec, ev, rem;
      ie = c & 1; te = (c >> 1) & 1; ir = (c >> 2) & 1; tp = (c >> 3) & 1;
      ec = (ie & ir) | (te & tp);
      ev = ec == 0 ? 0 : ((ie & ir) != 0 ? 3 : 7);
      rem = te & tp & ((ev == 7) ? 0 : 1);
      do_reset();
      ibf_set = ie[0]; tmr_set = te[0]; tmr_ovf = tp[0]; tick();
      ibf_req = ir[0]; fetch = 1; tick();
      chk_out($sformatf("R4 R5 sweep %0d first", c), ec, ev);
      ibf_req = 0; retr = 1; retr2 = 1; fetch = 1; tick();
      chk_out($sformatf("R7 R8 sweep %0d after rearm", c), rem, rem != 0 ? 7 : 0);
      tick();
      chk_out($sformatf("R3 sweep %0d idle", c), 0, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule